// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block turns a pixel position on a render surface into the byte offset of that pixel from the start of the surface. The caller supplies the pixel column and row, the origin of the drawable inside the surface, the pixel size, the surface pitch in pixels, a layout select and a bit-6 swizzle select. One request may be issued each clock cycle with a valid strobe. The offset comes back from a register one cycle later.

Three layouts are supported. In the linear layout, rows follow one another directly. The two tiled layouts divide the surface into 4096-byte tiles. The wide tile holds 8 rows of 512 bytes. The tall tile holds 32 rows of 128 bytes, stored as 16-byte columns. The swizzle select can replace bit 6 of the in-tile offset with an XOR of that bit and higher in-tile bits. This spreads neighbouring rows across cache sets.

Top module: `tile_addr_xlate`

## Requirements
- R1: The origin is added to the pixel coordinates before any layout arithmetic: the effective column is `px_x + org_x` and the effective row is `px_y + org_y`. The byte column is the effective column times the pixel size, where `wide_px` = 0 means 2 bytes and `wide_px` = 1 means 4 bytes.
- R2: When `layout` is 0 or 3, the offset is (row × pitch + column) × pixel size.
- R3: When `layout` is 1 (wide tile):
  - The in-tile offset is (row mod 8) × 512 + (byte column mod 512).
  - The tile base is (byte column ÷ 512) × 4096 + (row ÷ 8) × pitch × pixel size × 8.
- R4: When `layout` is 2 (tall tile):
  - The in-tile offset is ((byte column mod 128) ÷ 16) × 512 + (row mod 32) × 16 + (byte column mod 16).
  - The tile base is (byte column ÷ 128) × 4096 + (row ÷ 32) × pitch × pixel size × 32.
- R5: When `swz_sel` is 0 or 3, the in-tile offset is not changed in either tiled layout.
- R6: In the wide tile, `swz_sel` = 1 replaces in-tile bit 6 with bit6^bit9^bit10. `swz_sel` = 2 replaces it with bit6^bit9^bit10^bit11.
- R7: In the tall tile, `swz_sel` = 1 replaces in-tile bit 6 with bit6^bit9. `swz_sel` = 2 leaves the offset unchanged.
- R8: The swizzle acts only on bit 6 of the 12-bit in-tile offset. It is applied before the tile base is added.
- R9: `out_valid` follows `in_valid` exactly one cycle later. `byte_off` is loaded only when `in_valid` is high and otherwise holds its value.
- R10: While `rst_n` is low, `out_valid` and `byte_off` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| px_x | input | 13 | Pixel column |
| px_y | input | 13 | Pixel row |
| org_x | input | 13 | Drawable origin column |
| org_y | input | 13 | Drawable origin row |
| wide_px | input | 1 | Pixel size: 0 = 2 bytes, 1 = 4 bytes |
| pitch | input | 14 | Surface pitch in pixels |
| layout | input | 2 | 0/3 = linear, 1 = wide tile, 2 = tall tile |
| swz_sel | input | 2 | Bit-6 swizzle select |
| out_valid | output | 1 | Result strobe |
| byte_off | output | 32 | Registered byte offset |

## Verification
The swizzle and the tile-base addition act on the same request in the same cycle. A fault in their ordering only shows when the in-tile bits 9 to 11 are nonzero and the tile column or tile row is also nonzero. Vectors are therefore chosen near tile edges, with nonzero origins, so that bit 6 flips and a nonzero base is added at the same time. Each result is compared with a model that swizzles the 12-bit in-tile offset first and only then adds the base. Back-to-back random requests across every layout and swizzle pairing exercise the same overlap at full rate.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  localparam int COORD_W = 13;
  localparam int PITCH_W = 14;
  localparam int OFF_W   = 32;
  localparam int TILE_LOG2 = 12;

  typedef enum logic [1:0] {
    LAY_LINEAR  = 2'd0,
    LAY_WIDE    = 2'd1,
    LAY_TALL    = 2'd2,
    LAY_LINEAR2 = 2'd3
  } layout_e;

  typedef enum logic [1:0] {
    SWZ_OFF  = 2'd0,
    SWZ_TWO  = 2'd1,
    SWZ_FULL = 2'd2,
    SWZ_OFF2 = 2'd3
  } swz_e;
endpackage

// File: rtl/tile_coord_prep.sv
module tile_coord_prep #(
  parameter int COORD_W = 13,
  localparam int ABS_W  = COORD_W + 1,
  localparam int BCOL_W = ABS_W + 2
) (
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic               wide_px,
  output logic [ABS_W-1:0]   abs_x,
  output logic [ABS_W-1:0]   abs_y,
  output logic [BCOL_W-1:0]  byte_col
);
  always_comb begin
    abs_x = ABS_W'(px_x) + ABS_W'(org_x);
    abs_y = ABS_W'(px_y) + ABS_W'(org_y);
    if (wide_px) byte_col = {abs_x, 2'b00};
    else         byte_col = {1'b0, abs_x, 1'b0};
  end
endmodule

// File: rtl/tile_geom.sv
module tile_geom
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 13,
  parameter int PITCH_W = 14,
  parameter int OFF_W   = 32,
  parameter bit TALL    = 1'b0,
  localparam int ABS_W  = COORD_W + 1,
  localparam int BCOL_W = ABS_W + 2,
  localparam int COL_SHIFT = TALL ? 7 : 9,
  localparam int ROW_SHIFT = TALL ? 5 : 3
) (
  input  logic [ABS_W-1:0]     abs_y,
  input  logic [BCOL_W-1:0]    byte_col,
  input  logic [PITCH_W-1:0]   pitch,
  input  logic                 wide_px,
  input  logic [1:0]           swz_sel,
  output logic [TILE_LOG2-1:0] intile_raw,
  output logic [TILE_LOG2-1:0] intile_swz,
  output logic [OFF_W-1:0]     tiled_off
);
  logic       flip6;
  logic [OFF_W-1:0] pitch_bytes, stride, col_idx, row_idx, tile_base;

  generate
    if (TALL) begin : g_tall
      always_comb begin
        intile_raw = {byte_col[6:4], abs_y[4:0], byte_col[3:0]};
        flip6 = (swz_e'(swz_sel) == SWZ_TWO) ? intile_raw[9] : 1'b0;
      end
    end else begin : g_wide
      always_comb begin
        intile_raw = {abs_y[2:0], byte_col[8:0]};
        unique case (swz_e'(swz_sel))
          SWZ_TWO:  flip6 = intile_raw[9] ^ intile_raw[10];
          SWZ_FULL: flip6 = intile_raw[9] ^ intile_raw[10] ^ intile_raw[11];
          default:  flip6 = 1'b0;
        endcase
      end
    end
  endgenerate

  always_comb begin
    intile_swz  = intile_raw ^ (TILE_LOG2'(flip6) << 6);
    pitch_bytes = wide_px ? (OFF_W'(pitch) << 2) : (OFF_W'(pitch) << 1);
    stride      = pitch_bytes << ROW_SHIFT;
    col_idx     = OFF_W'(byte_col >> COL_SHIFT);
    row_idx     = OFF_W'(abs_y >> ROW_SHIFT);
    tile_base   = (col_idx << TILE_LOG2) + row_idx * stride;
    tiled_off   = tile_base + OFF_W'(intile_swz);
  end
endmodule

// File: rtl/tile_addr_xlate.sv
module tile_addr_xlate
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = tile_addr_pkg::COORD_W,
  parameter int PITCH_W = tile_addr_pkg::PITCH_W,
  parameter int OFF_W   = tile_addr_pkg::OFF_W,
  localparam int ABS_W  = COORD_W + 1,
  localparam int BCOL_W = ABS_W + 2,
  localparam int N_GEOM = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic               wide_px,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [1:0]         layout,
  input  logic [1:0]         swz_sel,
  output logic               out_valid,
  output logic [OFF_W-1:0]   byte_off
);
  logic [ABS_W-1:0]  abs_x, abs_y;
  logic [BCOL_W-1:0] byte_col;
  logic [TILE_LOG2-1:0] g_raw [N_GEOM];
  logic [TILE_LOG2-1:0] g_swz [N_GEOM];
  logic [OFF_W-1:0]     g_off [N_GEOM];
  logic [OFF_W-1:0] lin_pix, lin_off, sel_off, off_d;
  logic             vld_d;

  tile_coord_prep #(.COORD_W(COORD_W)) u_prep (
    .px_x(px_x), .px_y(px_y), .org_x(org_x), .org_y(org_y),
    .wide_px(wide_px), .abs_x(abs_x), .abs_y(abs_y), .byte_col(byte_col)
  );

  // index 0 = wide tile, index 1 = tall tile
  for (genvar g = 0; g < N_GEOM; g++) begin : g_geom
    tile_geom #(
      .COORD_W(COORD_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W), .TALL(g == 1)
    ) u_geom (
      .abs_y(abs_y), .byte_col(byte_col), .pitch(pitch), .wide_px(wide_px),
      .swz_sel(swz_sel), .intile_raw(g_raw[g]), .intile_swz(g_swz[g]),
      .tiled_off(g_off[g])
    );
  end

  always_comb begin
    lin_pix = OFF_W'(abs_y) * OFF_W'(pitch) + OFF_W'(abs_x);
    lin_off = wide_px ? (lin_pix << 2) : (lin_pix << 1);
    unique case (layout_e'(layout))
      LAY_WIDE: sel_off = g_off[0];
      LAY_TALL: sel_off = g_off[1];
      default:  sel_off = lin_off;
    endcase
    vld_d = in_valid;
    off_d = in_valid ? sel_off : byte_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      byte_off  <= '0;
    end else begin
      out_valid <= vld_d;
      byte_off  <= off_d;
    end
  end

  // R9: strobe latency and hold
  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(byte_off));
  // R8: swizzle touches only in-tile bit 6, in both geometries
  p_swz_bit6_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((g_raw[0] ^ g_swz[0]) & ~TILE_LOG2'(12'h040)) == '0);
  p_swz_bit6_tall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((g_raw[1] ^ g_swz[1]) & ~TILE_LOG2'(12'h040)) == '0);
  // R5: select 0 or 3 leaves both in-tile offsets untouched
  p_swz_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (swz_sel == 2'd0 || swz_sel == 2'd3))
      |-> (g_raw[0] == g_swz[0] && g_raw[1] == g_swz[1]));
  // R7: tall tile ignores select 2
  p_tall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && swz_sel == 2'd2) |-> g_raw[1] == g_swz[1]);
endmodule

// File: tb/tile_addr_xlate_bench.sv
module tile_addr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [12:0] px_x, px_y, org_x, org_y;
  logic        wide_px;
  logic [13:0] pitch;
  logic [1:0]  layout, swz_sel;
  logic        out_valid;
  logic [31:0] byte_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tile_addr_xlate u_tile_addr_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .px_x(px_x), .px_y(px_y),
    .org_x(org_x), .org_y(org_y), .wide_px(wide_px), .pitch(pitch),
    .layout(layout), .swz_sel(swz_sel), .out_valid(out_valid), .byte_off(byte_off)
  );

  typedef struct packed {
    logic [12:0] x, y, ox, oy;
    logic        w;
    logic [13:0] p;
    logic [1:0]  lay, sw;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{13'd10,  13'd3,  13'd0, 13'd0, 1'b0, 14'd100, 2'd0, 2'd0, 32'd620},   // R2
    '{13'd5,   13'd2,  13'd3, 13'd1, 1'b1, 14'd64,  2'd3, 2'd0, 32'd800},   // R1 R2
    '{13'd130, 13'd9,  13'd0, 13'd0, 1'b1, 14'd256, 2'd1, 2'd0, 32'd12808}, // R3
    '{13'd130, 13'd9,  13'd0, 13'd0, 1'b1, 14'd256, 2'd1, 2'd1, 32'd12872}, // R6
    '{13'd130, 13'd15, 13'd0, 13'd0, 1'b1, 14'd256, 2'd1, 2'd2, 32'd15944}, // R6 R8
    '{13'd130, 13'd15, 13'd0, 13'd0, 1'b1, 14'd256, 2'd1, 2'd1, 32'd15880}, // R6
    '{13'd20,  13'd33, 13'd0, 13'd0, 1'b1, 14'd128, 2'd2, 2'd0, 32'd18960}, // R4
    '{13'd20,  13'd33, 13'd0, 13'd0, 1'b1, 14'd128, 2'd2, 2'd1, 32'd19024}, // R7
    '{13'd20,  13'd33, 13'd0, 13'd0, 1'b1, 14'd128, 2'd2, 2'd2, 32'd18960}, // R7
    '{13'd130, 13'd9,  13'd0, 13'd0, 1'b1, 14'd256, 2'd1, 2'd3, 32'd12808}  // R5
  };

  function automatic longint model(input int x, input int y, input int ox, input int oy,
                                   input bit w, input int p, input int lay, input int sw);
    longint ax, ay, bpp, bc, intile, base, b6;
    ax = x + ox; ay = y + oy; bpp = w ? 4 : 2; bc = ax * bpp;
    if (lay == 1) begin
      intile = (ay % 8) * 512 + (bc % 512);
      b6 = 0;
      if (sw == 1) b6 = ((intile >> 9) ^ (intile >> 10)) & 1;
      if (sw == 2) b6 = ((intile >> 9) ^ (intile >> 10) ^ (intile >> 11)) & 1;
      intile = intile ^ (b6 * 64);
      base = (bc / 512) * 4096 + (ay / 8) * p * bpp * 8;
      return (base + intile) & 64'hFFFF_FFFF;
    end else if (lay == 2) begin
      intile = ((bc % 128) / 16) * 512 + (ay % 32) * 16 + (bc % 16);
      b6 = (sw == 1) ? ((intile >> 9) & 1) : 0;
      intile = intile ^ (b6 * 64);
      base = (bc / 128) * 4096 + (ay / 32) * p * bpp * 32;
      return (base + intile) & 64'hFFFF_FFFF;
    end
    return ((ay * p + ax) * bpp) & 64'hFFFF_FFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    px_x = v.x; px_y = v.y; org_x = v.ox; org_y = v.oy; wide_px = v.w;
    pitch = v.p; layout = v.lay; swz_sel = v.sw;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    vec_t v;
    longint e;
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid in reset", 32'(out_valid), 32'd0);
    check("R10 offset in reset", byte_off, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 valid vec%0d", i), 32'(out_valid), 32'd1);
      check($sformatf("R1-table vec%0d R3 R4 R6 R7", i), byte_off, VECS[i].exp);
    end

    // R9 hold: idle cycle with changed inputs
    @(negedge clk);
    held = byte_off;
    drive(VECS[6]);
    @(negedge clk);
    check("R9 idle valid", 32'(out_valid), 32'd0);
    check("R9 hold offset", byte_off, held);

    // R8 corner: tile base and bit-6 flip together, nonzero origin
    v = '{13'd1000, 13'd4000, 13'd777, 13'd95, 1'b1, 14'd9000, 2'd1, 2'd2, 32'd0};
    @(negedge clk); drive(v); in_valid = 1'b1;
    e = model(1000, 4000, 777, 95, 1'b1, 9000, 1, 2);
    @(negedge clk); in_valid = 1'b0;
    check("R8 wide corner", byte_off, 32'(e));
    v.lay = 2'd2; v.sw = 2'd1;
    @(negedge clk); drive(v); in_valid = 1'b1;
    e = model(1000, 4000, 777, 95, 1'b1, 9000, 2, 1);
    @(negedge clk); in_valid = 1'b0;
    check("R8 tall corner", byte_off, 32'(e));

    // back-to-back random across all layouts and selects (R1..R7)
    e = -1;
    for (int i = 0; i < 600; i++) begin
      int rx, ry, rox, roy, rp, rl, rs;
      bit rw;
      @(negedge clk);
      if (e >= 0) begin
        check("R9 stream valid", 32'(out_valid), 32'd1);
        check("R3 R4 R6 R7 stream", byte_off, 32'(e));
      end
      rx = $urandom_range(8191); ry = $urandom_range(8191);
      rox = $urandom_range(8191); roy = $urandom_range(8191);
      rp = $urandom_range(16383); rw = 1'($urandom_range(1));
      rl = i % 4; rs = (i / 4) % 4;
      px_x = 13'(rx); px_y = 13'(ry); org_x = 13'(rox); org_y = 13'(roy);
      pitch = 14'(rp); wide_px = rw; layout = 2'(rl); swz_sel = 2'(rs);
      in_valid = 1'b1;
      e = model(rx, ry, rox, roy, rw, rp, rl, rs);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 R4 stream last", byte_off, 32'(e));

    // R10 reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R10 async clear valid", 32'(out_valid), 32'd0);
    check("R10 async clear offset", byte_off, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 32'(out_valid), 32'd0);
    finish_run();
  end
endmodule